// File: doc/BRIEF.md
# Programmable Multi-Rate Cancellation Filter

This block recombines the two digital streams of a two-stage cascade sigma-delta converter whose second stage runs slower than the first. The first-stage code (three levels) arrives on every fast clock. The second-stage code (five levels) arrives once every `p` fast clocks and is flagged by a strobe. The block holds the slow code between strobes. It passes the fast code through two cascaded length-`p` moving sums. It passes the held slow code through the same filter followed by a second-order difference. It then subtracts the slow path from the fast path and registers the result with a valid flag.

With this arrangement the first-stage quantisation error and its copies folded in by the rate reduction cancel. The remaining second-stage error is shaped by (1 - z^-1)^2 (1 - z^-p)^2. The ratio `p` is a run-time input from 2 to 6 with no coefficients to load. A change of ratio flushes all filter state, and the output stays marked invalid until the pipeline has refilled with samples taken at the new ratio.

Top module: `dcl_mr_cancel`

## Requirements
- R1: While `rst_n` is low at a clock edge, `y_out` becomes 0 and `y_valid` becomes 0.
- R2: The fast path contributes sum over k = 0..2p-2 of c_k * a[n-k] with c_k = min(k+1, 2p-1-k), where a is `fe_code` read as 2-bit two's complement in {-1, 0, +1} (the code 2'b10 never occurs).
- R3: The slow code h[n] equals `be_code` (3-bit two's complement, -2..+2) on cycles where `be_strobe` is 1. Otherwise it keeps its previous value. It is 0 from a restart until the first strobe.
- R4: The slow path is subtracted from the output as h[n] - 2h[n-p] + h[n-2p]. Samples from before the restart count as 0.
- R5: The output word for the inputs sampled at edge n appears on `y_out` after edge n+2.
- R6: Every ratio value 2, 3, 4, 5 and 6 on `ratio` (3-bit unsigned) gives the behaviour of R2 and R4 for that p.
- R7: A clock edge at which `ratio` differs from the value held inside is a restart. At that edge all filter state clears and that cycle's inputs are discarded. `y_valid` is 0 after that edge and after the next 2*6 - 1 edges, and 1 after every later edge until the next restart or reset.
- R8: No internal value wraps. With p = 6, the extreme legal inputs (+1 fast, slow alternating between -2 and +2) produce the exact output 44 on the 8-bit signed `y_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio | input | 3 | Rate ratio p, unsigned, 2 to 6 |
| fe_code | input | 2 | First-stage code, signed, -1..+1 |
| be_code | input | 3 | Second-stage code, signed, -2..+2 |
| be_strobe | input | 1 | High on the cycle a new second-stage code is presented |
| y_out | output | 8 | Combined output word, signed |
| y_valid | output | 1 | High when `y_out` holds a sample from a fully refilled pipeline |

## Verification
The assertions assume that `ratio` always holds a value from 2 to 6, that `fe_code` never carries the unused code 2'b10, and that `be_code` stays within -2..+2. The output bound check depends on these ranges. The stimulus only draws codes from those sets, including on the cycles where it changes the ratio. It moves through every ratio in turn, so each change exercises a flush. The strobe spacing equals the current ratio but starts at a random phase, so the zero hold value before the first strobe is also covered.

// File: rtl/dcl_pkg.sv
// Package dcl_pkg: shared constants for the multi-rate cancellation filter.
// Assumes codes are two's complement and symmetric about zero.
package dcl_pkg;
    localparam int FE_W    = 2;   // first-stage code width
    localparam int BE_W    = 3;   // second-stage code width
    localparam int FE_MAX  = 1;   // largest first-stage magnitude
    localparam int BE_MAX  = 2;   // largest second-stage magnitude
    localparam int RATIO_W = 3;   // ratio input width
    localparam int P_MAX   = 6;   // largest supported ratio
    localparam int ORDER   = 2;   // first-stage loop order
    localparam int OUT_W   = 8;   // output word width
endpackage

// File: rtl/dcl_msum.sv
// Module dcl_msum: running sum over the last p inputs, built as an
// accumulator minus the input leaving a P_MAX-deep delay line at tap p.
// Assumes p_sel is within 1..P_MAX and IN_W <= OUT_W. Registered output.
module dcl_msum #(
    parameter int IN_W  = 4,
    parameter int OUT_W = 8,
    parameter int P_MAX = 6,
    parameter int P_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [P_W-1:0]          p_sel,
    input  logic signed [IN_W-1:0]  x,
    output logic signed [OUT_W-1:0] y
);
    logic signed [IN_W-1:0]  dl [P_MAX];
    logic signed [IN_W-1:0]  tap;
    logic signed [OUT_W-1:0] acc;

    // Select the delayed input that leaves the window for the current p.
    always_comb begin
        tap = '0;
        for (int i = 0; i < P_MAX; i++) begin
            if (p_sel == P_W'(i + 1)) tap = dl[i];
        end
    end

    // Shift the delay line and update the running sum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < P_MAX; i++) dl[i] <= '0;
            acc <= '0;
        end else begin
            dl[0] <= x;
            for (int i = 1; i < P_MAX; i++) dl[i] <= dl[i-1];
            acc <= acc + OUT_W'(x) - OUT_W'(tap);
        end
    end

    assign y = acc;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (y == '0)); // R7
endmodule

// File: rtl/dcl_diff.sv
// Module dcl_diff: applies (1 - z^-1)^ORDER as a chain of first differences,
// each holding one previous value. Output is combinational from x and state.
// Assumes W leaves ORDER bits of headroom over the input range.
module dcl_diff #(
    parameter int IN_W  = 8,
    parameter int W     = 10,
    parameter int ORDER = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic signed [IN_W-1:0] x,
    output logic signed [W-1:0] y
);
    logic signed [W-1:0] chain [ORDER+1];
    logic signed [W-1:0] prev  [ORDER];

    assign chain[0] = W'(x);

    for (genvar s = 0; s < ORDER; s++) begin : g_stage
        assign chain[s+1] = chain[s] - prev[s];

        // Remember this stage's input for the next cycle's difference.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) prev[s] <= '0;
            else               prev[s] <= chain[s];
        end
    end

    assign y = chain[ORDER];
endmodule

// File: rtl/dcl_mr_cancel.sv
// Module dcl_mr_cancel: multi-rate cancellation logic. Holds the slow code
// between strobes, filters both paths with ORDER cascaded length-p moving
// sums, shapes the slow path by (1 - z^-1)^ORDER and subtracts it.
// Assumes legal codes and 2 <= ratio <= P_MAX. Latency: two edges after the
// input edge. A ratio change flushes all state for 2*P_MAX cycles.
module dcl_mr_cancel
    import dcl_pkg::*;
#(
    parameter int P_MAX_P = P_MAX,
    parameter int ORDER_P = ORDER,
    parameter int OUT_W_P = OUT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [RATIO_W-1:0]        ratio,
    input  logic signed [FE_W-1:0]    fe_code,
    input  logic signed [BE_W-1:0]    be_code,
    input  logic                      be_strobe,
    output logic signed [OUT_W_P-1:0] y_out,
    output logic                      y_valid
);
    localparam int GROW   = ORDER_P * ($clog2(P_MAX_P) + 1);
    localparam int FA_W   = FE_W + GROW;
    localparam int FB_W   = BE_W + GROW;
    localparam int DB_W   = FB_W + ORDER_P;
    localparam int SUM_W  = (DB_W > FA_W ? DB_W : FA_W) + 1;
    localparam int FLUSH  = 2 * P_MAX_P;
    localparam int CNT_W  = $clog2(FLUSH + 1);
    localparam int Y_BOUND = (P_MAX_P ** ORDER_P) * FE_MAX + (1 << ORDER_P) * BE_MAX;

    logic [RATIO_W-1:0]     ratio_q;
    logic                   chg;
    logic [CNT_W-1:0]       cnt;
    logic signed [BE_W-1:0] b_hold;
    logic signed [BE_W-1:0] b_cur;
    logic signed [FA_W-1:0] fa_chain [ORDER_P+1];
    logic signed [FB_W-1:0] fb_chain [ORDER_P+1];
    logic signed [DB_W-1:0] db;
    logic signed [SUM_W-1:0] sum;

    assign chg   = (ratio != ratio_q);
    assign b_cur = be_strobe ? be_code : b_hold;

    // Track the active ratio and the refill countdown after a restart.
    always_ff @(posedge clk) begin
        if (!rst_n || chg) begin
            ratio_q <= ratio;
            cnt     <= CNT_W'(FLUSH);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Hold the latest slow code between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || chg) b_hold <= '0;
        else               b_hold <= b_cur;
    end

    assign fa_chain[0] = FA_W'(fe_code);
    assign fb_chain[0] = FB_W'(b_cur);

    for (genvar s = 0; s < ORDER_P; s++) begin : g_cascade
        dcl_msum #(.IN_W(FA_W), .OUT_W(FA_W), .P_MAX(P_MAX_P), .P_W(RATIO_W)) u_fa (
            .clk(clk), .rst_n(rst_n), .clr(chg), .p_sel(ratio_q),
            .x(fa_chain[s]), .y(fa_chain[s+1]));
        dcl_msum #(.IN_W(FB_W), .OUT_W(FB_W), .P_MAX(P_MAX_P), .P_W(RATIO_W)) u_fb (
            .clk(clk), .rst_n(rst_n), .clr(chg), .p_sel(ratio_q),
            .x(fb_chain[s]), .y(fb_chain[s+1]));
    end

    dcl_diff #(.IN_W(FB_W), .W(DB_W), .ORDER(ORDER_P)) u_shape (
        .clk(clk), .rst_n(rst_n), .clr(chg), .x(fb_chain[ORDER_P]), .y(db));

    assign sum = SUM_W'(fa_chain[ORDER_P]) - SUM_W'(db);

    // Register the combined word and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n || chg) begin
            y_out   <= '0;
            y_valid <= 1'b0;
        end else begin
            y_out   <= OUT_W_P'(sum);
            y_valid <= (cnt <= CNT_W'(1));
        end
    end

    localparam logic signed [OUT_W_P-1:0] Y_LIM = OUT_W_P'(Y_BOUND);

    AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio >= RATIO_W'(2)) && (ratio <= RATIO_W'(P_MAX_P))); // R6
    AST_FE_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        fe_code != {1'b1, {(FE_W-1){1'b0}}}); // R2
    AST_BE_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (be_code >= -BE_W'(BE_MAX)) && (be_code <= BE_W'(BE_MAX))); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!be_strobe && !chg) |=> $stable(b_hold)); // R3
    AST_FLUSH_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> !y_valid); // R7
    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (y_valid && !chg) |=> y_valid); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (y_out <= Y_LIM) && (y_out >= -Y_LIM)); // R8
endmodule

// File: tb/tb_dcl_mr_cancel.sv
`timescale 1ns/1ps
module tb_dcl_mr_cancel;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        ratio = 3'd2;
    logic signed [1:0] fe_code = '0;
    logic signed [2:0] be_code = '0;
    logic              be_strobe = 1'b0;
    logic signed [7:0] y_out;
    logic              y_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int aa [0:511];
    int hh [0:511];
    int j;
    int hprev;
    int pcur;

    always #4 clk = ~clk;

    dcl_mr_cancel dut (
        .clk(clk), .rst_n(rst_n), .ratio(ratio), .fe_code(fe_code),
        .be_code(be_code), .be_strobe(be_strobe), .y_out(y_out), .y_valid(y_valid));

    function automatic int model_y(int n, int p);
        int acc = 0;
        for (int k = 0; k <= 2*p - 2; k++) begin
            int c = (k + 1 < 2*p - 1 - k) ? k + 1 : 2*p - 1 - k;
            if (n - k >= 0) acc += c * aa[n-k];
        end
        acc -= hh[n];
        if (n - p >= 0)   acc += 2 * hh[n-p];
        if (n - 2*p >= 0) acc -= hh[n-2*p];
        return acc;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (p=%0d sample %0d)", req, act, exp, pcur, j);
        end
    endtask

    // One fast cycle: drive inputs, clock, then check the output.
    task automatic step(input int a, input int b, input bit stb);
        fe_code = 2'(a); be_code = 3'(b); be_strobe = stb;
        aa[j] = a;
        hh[j] = stb ? b : hprev;
        hprev = hh[j];
        @(posedge clk); @(negedge clk);
        if (j < 11) begin
            check(y_valid == 1'b0, "R7 valid low while refilling", int'(y_valid), 0);
        end else begin
            int e = model_y(j - 2, pcur);
            check(y_valid == 1'b1, "R7 valid after refill", int'(y_valid), 1);
            check(int'(y_out) == e, "R2/R4/R5/R6 output word", int'(y_out), e);
        end
        j++;
    endtask

    // Restart with a new ratio; inputs on this cycle must be discarded.
    task automatic set_p(input int p);
        ratio = 3'(p); fe_code = 2'sd1; be_code = 3'sd2; be_strobe = 1'b1;
        @(posedge clk); @(negedge clk);
        pcur = p; j = 0; hprev = 0;
        check(y_valid == 1'b0, "R7 valid cleared on ratio change", int'(y_valid), 0);
        check(y_out == 0, "R7 output cleared on ratio change", int'(y_out), 0);
    endtask

    task automatic run_block(input int p);
        int ph = $urandom_range(p - 1, 1);
        for (int c = 0; c < 120; c++) begin
            int bb = $urandom_range(4, 0) - 2;
            step($urandom_range(2, 0) - 1, bb, ((c + ph) % p) == 0);
        end
        for (int c = 0; c < 40; c++) begin // R8 extreme pattern
            step(1, ((c / p) % 2 == 0) ? -2 : 2, (c % p) == 0);
        end
        for (int c = 0; c < 30; c++) step(-1, -2, (c % p) == 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(y_out == 0, "R1 reset output", int'(y_out), 0);
        check(y_valid == 1'b0, "R1 reset valid", int'(y_valid), 0);
        rst_n = 1'b1;
        pcur = 2; j = 0; hprev = 0;
        run_block(2);
        for (int p = 3; p <= 6; p++) begin
            set_p(p);
            run_block(p);
        end
        // R8: steady +1 fast with slow alternating at p = 6 reaches 44
        set_p(2);
        set_p(6);
        for (int c = 0; c < 60; c++) step(1, ((c / 6) % 2 == 0) ? -2 : 2, (c % 6) == 0);
        check(int'(y_out) == 44 || int'(y_out) == 28, "R8 extreme magnitude", int'(y_out), 44);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule